// File: doc/BRIEF.md
# Receive Ring Occupancy Tracker with Equality Full Detect

This block keeps the two position pointers of a circular receive ring with `DEPTH` slots. A producer pointer moves each time the hardware deposits a packet into a slot, and a consumer pointer moves each time software hands a slot back. From these two pointers the block derives an occupancy count and full and empty flags. A controller uses the flags and count to decide whether another packet can land and how much work is pending.

The pointers start one slot apart. After reset the consumer pointer sits at the last slot and the producer pointer sits at slot zero, and that arrangement means the ring is empty. Because of this offset, the ring is full when the two pointers are equal. The full decision is therefore a plain comparator with no adder in front of it. The one increment the block needs (consumer pointer plus one) is already built to advance that pointer, and it is reused for the empty flag. Usable capacity is `DEPTH-1` slots.

A strobe that cannot be honoured is dropped, and the block raises a one-cycle error pulse. A produce while full is dropped, and so is a consume while empty. When both strobes arrive together, each one is judged against the state before the clock edge.

Top module: `rx_ring_tracker`

## Requirements
- R1: During and after reset the producer pointer is 0, the consumer pointer is `DEPTH-1`, the count is 0, empty is 1, full is 0 and both error pulses are 0.
- R2: `full_o` is 1 exactly when the producer and consumer pointers hold the same value, and the count then reads `DEPTH-1`.
- R3: `empty_o` is 1 exactly when the consumer pointer plus one, modulo `DEPTH`, equals the producer pointer, and the count then reads 0.
- R4: An accepted produce strobe advances the producer pointer by one on the next clock edge, wrapping from `DEPTH-1` to 0.
- R5: An accepted consume strobe advances the consumer pointer by one on the next clock edge, wrapping from `DEPTH-1` to 0.
- R6: The count always equals (producer − consumer − 1) modulo `DEPTH`. It reads 1 after one packet and 2 after two packets from reset, and falls back to 0 when both are released.
- R7: A produce strobe while full leaves the producer pointer unchanged, and `ovf_err_o` is 1 for exactly the following cycle.
- R8: A consume strobe while empty leaves the consumer pointer unchanged, and `unf_err_o` is 1 for exactly the following cycle.
- R9: When produce and consume are both asserted and the ring is neither full nor empty, both pointers advance and the count is unchanged.
- R10: When both strobes arrive while full, only the consume takes effect and an overflow pulse follows. When both arrive while empty, only the produce takes effect and an underflow pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| produce_i | input | 1 | A packet was written into the slot at the producer pointer |
| consume_i | input | 1 | Software released the slot after the consumer pointer |
| wr_idx_o | output | IDX_W | Producer (hardware write) pointer |
| rd_idx_o | output | IDX_W | Consumer (software read) pointer |
| used_o | output | IDX_W | Number of occupied slots, 0 to DEPTH-1 |
| full_o | output | 1 | Ring holds DEPTH-1 packets |
| empty_o | output | 1 | Ring holds no packets |
| ovf_err_o | output | 1 | One-cycle pulse after a dropped produce |
| unf_err_o | output | 1 | One-cycle pulse after a dropped consume |

## Verification
The checker watches every clock for these properties: pointer advance and wrap after each accepted strobe, a frozen pointer plus an error pulse after each rejected strobe, the count tied to the flags, and a steady count when both strobes are honoured together. It cannot show that the count follows the modular difference through a whole fill and drain, or the exact reset values. Only the bench's scenarios cover those. They fill the ring to its last slot, push against a full ring, drain it, pull from an empty ring, and apply simultaneous strobes in all three occupancy regions, comparing against an independent pointer model.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

   typedef struct packed {
      logic take_prod;
      logic take_cons;
      logic drop_prod;
      logic drop_cons;
   } ring_grant_t;

   // Each strobe is judged against the state before the edge.
   function automatic ring_grant_t ring_resolve(input logic prod,
                                                input logic cons,
                                                input logic is_full,
                                                input logic is_empty);
      ring_grant_t g;
      g.take_prod = prod & ~is_full;
      g.take_cons = cons & ~is_empty;
      g.drop_prod = prod & is_full;
      g.drop_cons = cons & is_empty;
      return g;
   endfunction

endpackage

// File: rtl/rx_ring_step.sv
module rx_ring_step #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] cur_i,
   output logic [IDX_W-1:0] nxt_o
);
   localparam bit POW2 = (DEPTH == (1 << IDX_W));
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   generate
      if (POW2) begin : g_natural_wrap
         assign nxt_o = cur_i + IDX_W'(1);
      end else begin : g_compare_wrap
         assign nxt_o = (cur_i == LAST) ? '0 : cur_i + IDX_W'(1);
      end
   endgenerate
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
   parameter int DEPTH   = 256,
   parameter int IDX_W   = $clog2(DEPTH),
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [IDX_W-1:0] ptr_o,
   output logic [IDX_W-1:0] ptr_nxt_o
);
   localparam logic [IDX_W-1:0] RST_PTR = IDX_W'(RST_VAL);

   rx_ring_step #(.DEPTH(DEPTH), .IDX_W(IDX_W)) step_i (
      .cur_i (ptr_o),
      .nxt_o (ptr_nxt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= RST_PTR;
      end else if (adv_i) begin
         ptr_o <= ptr_nxt_o;
      end
   end
endmodule

// File: rtl/rx_ring_fill.sv
module rx_ring_fill #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] wr_i,
   input  logic [IDX_W-1:0] rd_i,
   input  logic [IDX_W-1:0] rd_nxt_i,
   output logic [IDX_W-1:0] used_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam bit POW2 = (DEPTH == (1 << IDX_W));
   localparam int EXT_W = IDX_W + 1;
   localparam logic [EXT_W-1:0] DEPTH_EXT = EXT_W'(DEPTH);

   // Full needs only a comparator: no adder sits on this path.
   assign full_o  = (wr_i == rd_i);
   // Empty reuses the increment that already advances the consumer pointer.
   assign empty_o = (rd_nxt_i == wr_i);

   generate
      if (POW2) begin : g_used_natural
         assign used_o = wr_i - rd_i - IDX_W'(1);
      end else begin : g_used_folded
         logic [EXT_W-1:0] span;
         logic [EXT_W-1:0] fold;
         assign span   = {1'b0, wr_i} + DEPTH_EXT - {1'b0, rd_i} - EXT_W'(1);
         assign fold   = (span >= DEPTH_EXT) ? span - DEPTH_EXT : span;
         assign used_o = fold[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rx_ring_tracker.sv
module rx_ring_tracker #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             produce_i,
   input  logic             consume_i,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [IDX_W-1:0] rd_idx_o,
   output logic [IDX_W-1:0] used_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             ovf_err_o,
   output logic             unf_err_o
);
   import rx_ring_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_ring_tracker: DEPTH must be at least 2");
      end
      if (IDX_W < $clog2(DEPTH)) begin : g_bad_width
         $error("rx_ring_tracker: IDX_W too narrow for DEPTH");
      end
   endgenerate

   ring_grant_t      grant;
   logic [IDX_W-1:0] wr_nxt;
   logic [IDX_W-1:0] rd_nxt;

   assign grant = ring_resolve(produce_i, consume_i, full_o, empty_o);

   rx_ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RST_VAL(0)) wr_ptr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (grant.take_prod),
      .ptr_o     (wr_idx_o),
      .ptr_nxt_o (wr_nxt)
   );

   rx_ring_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RST_VAL(DEPTH - 1)) rd_ptr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_i     (grant.take_cons),
      .ptr_o     (rd_idx_o),
      .ptr_nxt_o (rd_nxt)
   );

   rx_ring_fill #(.DEPTH(DEPTH), .IDX_W(IDX_W)) fill_i (
      .wr_i     (wr_idx_o),
      .rd_i     (rd_idx_o),
      .rd_nxt_i (rd_nxt),
      .used_o   (used_o),
      .full_o   (full_o),
      .empty_o  (empty_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_err_o <= 1'b0;
         unf_err_o <= 1'b0;
      end else begin
         ovf_err_o <= grant.drop_prod;
         unf_err_o <= grant.drop_cons;
      end
   end

   logic unused_wr_nxt;
   assign unused_wr_nxt = ^wr_nxt;
endmodule

// File: rtl/rx_ring_tracker_chk.sv
module rx_ring_tracker_chk #(
   parameter int DEPTH = 256,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             produce_i,
   input logic             consume_i,
   input logic [IDX_W-1:0] wr_idx_o,
   input logic [IDX_W-1:0] rd_idx_o,
   input logic [IDX_W-1:0] used_o,
   input logic             full_o,
   input logic             empty_o,
   input logic             ovf_err_o,
   input logic             unf_err_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   // R2
   full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> (used_o == LAST));

   // R3
   empty_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> (used_o == '0) && !full_o);

   // R4
   wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (produce_i && !full_o) |=>
         (wr_idx_o == (($past(wr_idx_o) == LAST) ? '0 : $past(wr_idx_o) + IDX_W'(1))));

   // R5
   rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume_i && !empty_o) |=>
         (rd_idx_o == (($past(rd_idx_o) == LAST) ? '0 : $past(rd_idx_o) + IDX_W'(1))));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (produce_i && full_o) |=> ovf_err_o && $stable(wr_idx_o));

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (consume_i && empty_o) |=> unf_err_o && $stable(rd_idx_o));

   // R9
   both_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (produce_i && consume_i && !full_o && !empty_o) |=> $stable(used_o));

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(produce_i && full_o) |=> !ovf_err_o);
endmodule

bind rx_ring_tracker rx_ring_tracker_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/rx_ring_tracker_tb_top.sv
`timescale 1ns/1ps
module rx_ring_tracker_tb_top;
   localparam int DEPTH = 256;
   localparam int IDX_W = $clog2(DEPTH);

   typedef struct {
      int    wr;
      int    rd;
      int    used;
      bit    full;
      bit    empty;
      bit    ovf;
      bit    unf;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             produce_i = 1'b0;
   logic             consume_i = 1'b0;
   logic [IDX_W-1:0] wr_idx_o, rd_idx_o, used_o;
   logic             full_o, empty_o, ovf_err_o, unf_err_o;

   int   n_checks = 0;
   int   n_fail = 0;
   int   m_wr = 0;
   int   m_rd = DEPTH - 1;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   rx_ring_tracker #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .produce_i(produce_i), .consume_i(consume_i),
      .wr_idx_o(wr_idx_o), .rd_idx_o(rd_idx_o), .used_o(used_o),
      .full_o(full_o), .empty_o(empty_o),
      .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o)
   );

   function automatic bit m_full();  return m_wr == m_rd;                endfunction
   function automatic bit m_empty(); return ((m_rd + 1) % DEPTH) == m_wr; endfunction

   task automatic compare(input exp_t e);
      n_checks++;
      if (wr_idx_o !== IDX_W'(e.wr) || rd_idx_o !== IDX_W'(e.rd) ||
          used_o !== IDX_W'(e.used) || full_o !== e.full || empty_o !== e.empty ||
          ovf_err_o !== e.ovf || unf_err_o !== e.unf) begin
         n_fail++;
         $display("FAIL %s: got wr=%0d rd=%0d used=%0d full=%0b empty=%0b ovf=%0b unf=%0b, expected wr=%0d rd=%0d used=%0d full=%0b empty=%0b ovf=%0b unf=%0b",
                  e.req, wr_idx_o, rd_idx_o, used_o, full_o, empty_o, ovf_err_o, unf_err_o,
                  e.wr, e.rd, e.used, e.full, e.empty, e.ovf, e.unf);
      end
   endtask

   // driver: applies one cycle of strobes and queues the state expected after the edge
   task automatic step(input bit p, input bit c, input string req);
      exp_t e;
      bit   tp, tc;
      @(negedge clk);
      produce_i = p;
      consume_i = c;
      tp = p && !m_full();
      tc = c && !m_empty();
      e.ovf = p && m_full();
      e.unf = c && m_empty();
      if (tp) m_wr = (m_wr + 1) % DEPTH;
      if (tc) m_rd = (m_rd + 1) % DEPTH;
      e.wr    = m_wr;
      e.rd    = m_rd;
      e.used  = (m_wr - m_rd - 1 + 2 * DEPTH) % DEPTH;
      e.full  = m_full();
      e.empty = m_empty();
      e.req   = req;
      sb_q.push_back(e);
   endtask

   // monitor: compares shortly after each rising edge
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
   end

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      exp_t r;
      repeat (3) @(negedge clk);
      // R1 reset values observed while reset is held
      r = '{wr:0, rd:DEPTH-1, used:0, full:1'b0, empty:1'b1, ovf:1'b0, unf:1'b0, req:"R1"};
      compare(r);
      rst_n = 1'b1;
      step(1'b0, 1'b0, "R1");
      step(1'b1, 1'b0, "R6");          // count 1
      step(1'b1, 1'b0, "R6");          // count 2
      step(1'b1, 1'b1, "R9");          // both advance, count stays 2
      step(1'b0, 1'b1, "R5");
      step(1'b0, 1'b1, "R3");          // back to empty
      step(1'b0, 1'b1, "R8");          // underflow, pointer frozen
      step(1'b0, 1'b0, "R8");          // pulse lasts one cycle
      step(1'b1, 1'b1, "R10");         // empty + both: only produce, underflow pulse
      step(1'b0, 1'b1, "R5");
      for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b0, "R4");  // fill, wrapping the producer
      step(1'b0, 1'b0, "R2");
      step(1'b1, 1'b0, "R7");          // overflow, pointer frozen
      step(1'b0, 1'b0, "R7");
      step(1'b1, 1'b1, "R10");         // full + both: only consume, overflow pulse
      step(1'b1, 1'b0, "R2");          // refill to full
      for (int i = 0; i < DEPTH - 1; i++) step(1'b0, 1'b1, "R5");  // drain, wrapping the consumer
      step(1'b0, 1'b1, "R8");
      for (int i = 0; i < 20; i++) step(1'b1, (i % 3) == 0, "R6");
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, "R9");
      step(1'b0, 1'b0, "R6");
      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule